// File: doc/BRIEF.md
# Delta-Sigma ADC Command Sequencer

This block controls an external four-register delta-sigma converter over a byte-framed SPI link and runs single-shot conversions on it without software involvement. After reset it sends the converter's reset opcode. It then waits for the converter to come out of reset and loads all four configuration registers with fixed start-up values. Only then does it report that it can accept work.

Each conversion request carries a single-ended channel index, a gain index and a data-rate code. The sequencer first rewrites the mux/gain register, which holds configuration register 0. If the rate code differs from the one last loaded, it also rewrites the rate register. It then issues the start opcode and waits the conversion time that belongs to the chosen rate. Finally it reads the 16-bit two's complement sample and presents it sign-extended with a one-cycle valid strobe.

All waits come from a microsecond tick. The tick is built from parameters so that the same RTL serves both silicon clock rates and short simulation runs.

Top module: `adc_seq`

## Requirements
- R1: After reset, the first frame is the single byte 0x06, and no further frame starts until at least RST_US*US_TICKS clock cycles after it ends. While reset is active: cs_n is 1, sclk is 0, req_ready is 0 and res_valid is 0.
- R2: The start-up sequence then writes registers 0, 1, 2 and 3 in that order with 0x81, 0x60, 0xC0 and 0x00. Each write is a two-byte frame: the first byte is 0x40 | (address << 2) and the second byte is the value. req_ready rises only after the fourth write.
- R3: A request is taken in a cycle where req_valid and req_ready are both 1. req_ready stays 0 from then until the result is delivered, and requests presented meanwhile have no effect.
- R4: Each conversion first writes register 0. Its value is bits 7:4 = 8 + channel, bits 3:1 = gain index and bit 0 = 1 (bypass bit kept as loaded at start-up).
- R5: Register 1 is rewritten as (rate code << 5) only when the effective rate code differs from the last one written. At start-up the last code is 3. Rate code 7 acts as code 6.
- R6: After the register writes, the single byte 0x08 is sent. Then the read frame is held off for ms(rate)*MS_US*US_TICKS cycles, with ms = 51, 24, 13, 7, 4, 3, 2 for codes 0 to 6. No frame is active during that wait.
- R7: The read frame is 24 clocks long: 0x10 followed by two bytes received MSB first. The 16-bit value appears on res_data, sign-extended to RES_W bits, with res_valid high for exactly one cycle.
- R8: The link uses SPI mode 1. sclk is low whenever cs_n is high. mosi changes only on a rising sclk. miso is sampled on a falling sclk. cs_n is low for a whole frame and high for at least two cycles between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Conversion request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_chan | input | 2 | Single-ended channel index |
| req_gain | input | 3 | Gain index (gain = 2^index) |
| req_rate | input | 3 | Data-rate code |
| res_valid | output | 1 | One-cycle strobe for res_data |
| res_data | output | RES_W | Sign-extended conversion result |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | SPI data to converter |
| miso | input | 1 | SPI data from converter |
| cs_n | output | 1 | SPI chip select, active low |

## Verification
The hardest case to reach from the ports is the skipped rate-register write. It appears only when a request's effective rate equals the rate left behind by an earlier conversion, including the case where code 7 is folded onto a preceding code 6. The vector table is therefore ordered so that repeated rates, a 6 followed by a 7, and rate changes alternate. A converter model counts register-1 writes and measures the gap between the start and read frames for each entry. A second directed case holds req_valid high with different fields for the whole of a conversion. This proves those fields never reach the converter registers.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int SCLK_DIV = 4,
  parameter int US_TICKS = 100,
  parameter int MS_US    = 1000,
  parameter int RST_US   = 200,
  parameter int RES_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_chan,
  input  logic [2:0]       req_gain,
  input  logic [2:0]       req_rate,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  localparam int HCW = $clog2(SCLK_DIV) + 1;
  localparam logic [31:0] RST_CYC = 32'(RST_US * US_TICKS);

  typedef enum logic [3:0] {S_RST, S_RWAIT, S_CFG, S_IDLE, S_MUX, S_RATE, S_START, S_CWAIT, S_READ} st_t;

  st_t         st;
  logic        pend, xfer, fdone;
  logic [1:0]  idx, chan;
  logic [2:0]  gain, rate, cur_rate;
  logic [31:0] wcnt;
  logic [23:0] fdat, tsh;
  logic [4:0]  fbits, bits_left;
  logic [15:0] rsh;
  logic [HCW-1:0] hc;
  logic [7:0]  cfg_val;

  function automatic logic [31:0] conv_cyc(input logic [2:0] r);
    int ms;
    case (r)
      3'd0: ms = 51;
      3'd1: ms = 24;
      3'd2: ms = 13;
      3'd3: ms = 7;
      3'd4: ms = 4;
      3'd5: ms = 3;
      default: ms = 2;
    endcase
    return 32'(ms * MS_US * US_TICKS);
  endfunction

  assign req_ready = (st == S_IDLE);

  always_comb
    case (idx)
      2'd0: cfg_val = 8'h81;
      2'd1: cfg_val = 8'h60;
      2'd2: cfg_val = 8'hC0;
      default: cfg_val = 8'h00;
    endcase

  always_comb begin
    fdat = '0;
    fbits = 5'd8;
    case (st)
      S_RST:   fdat = {8'h06, 16'h0};
      S_CFG:   begin fdat = {4'h4, idx, 2'b00, cfg_val, 8'h0}; fbits = 5'd16; end
      S_MUX:   begin fdat = {8'h40, 1'b1, 1'b0, chan, gain, 1'b1, 8'h0}; fbits = 5'd16; end
      S_RATE:  begin fdat = {8'h44, rate, 5'b0, 8'h0}; fbits = 5'd16; end
      S_START: fdat = {8'h08, 16'h0};
      S_READ:  begin fdat = {8'h10, 16'h0}; fbits = 5'd24; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer <= 1'b0; fdone <= 1'b0; cs_n <= 1'b1; sclk <= 1'b0; mosi <= 1'b0;
      hc <= '0; tsh <= '0; rsh <= '0; bits_left <= '0;
    end else begin
      fdone <= 1'b0;
      if (pend) begin
        tsh <= fdat; bits_left <= fbits; xfer <= 1'b1; cs_n <= 1'b0; hc <= '0;
      end else if (xfer) begin
        if (hc == HCW'(SCLK_DIV - 1)) begin
          hc <= '0;
          if (!sclk) begin
            if (bits_left == 5'd0) begin
              xfer <= 1'b0; cs_n <= 1'b1; fdone <= 1'b1;
            end else begin
              sclk <= 1'b1; mosi <= tsh[23]; tsh <= {tsh[22:0], 1'b0};
            end
          end else begin
            sclk <= 1'b0; rsh <= {rsh[14:0], miso}; bits_left <= bits_left - 5'd1;
          end
        end else hc <= hc + HCW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_RST; pend <= 1'b1; idx <= '0; wcnt <= '0; chan <= '0; gain <= '0;
      rate <= '0; cur_rate <= 3'd3; res_valid <= 1'b0; res_data <= '0;
    end else begin
      pend <= 1'b0;
      res_valid <= 1'b0;
      case (st)
        S_RST:   if (fdone) begin st <= S_RWAIT; wcnt <= RST_CYC; end
        S_RWAIT: if (wcnt == 0) begin st <= S_CFG; idx <= '0; pend <= 1'b1; end
                 else wcnt <= wcnt - 1;
        S_CFG:   if (fdone) begin
                   if (idx == 2'd3) st <= S_IDLE;
                   else begin idx <= idx + 2'd1; pend <= 1'b1; end
                 end
        S_IDLE:  if (req_valid) begin
                   chan <= req_chan; gain <= req_gain;
                   rate <= (req_rate == 3'd7) ? 3'd6 : req_rate;
                   st <= S_MUX; pend <= 1'b1;
                 end
        S_MUX:   if (fdone) begin
                   pend <= 1'b1;
                   if (rate != cur_rate) begin st <= S_RATE; cur_rate <= rate; end
                   else st <= S_START;
                 end
        S_RATE:  if (fdone) begin st <= S_START; pend <= 1'b1; end
        S_START: if (fdone) begin st <= S_CWAIT; wcnt <= conv_cyc(rate); end
        S_CWAIT: if (wcnt == 0) begin st <= S_READ; pend <= 1'b1; end
                 else wcnt <= wcnt - 1;
        S_READ:  if (fdone) begin
                   st <= S_IDLE; res_valid <= 1'b1;
                   res_data <= {{(RES_W-16){rsh[15]}}, rsh};
                 end
        default: st <= S_RST;
      endcase
    end
  end

  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n);
  p_mosi_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$rose(sclk)) |-> $stable(mosi));
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid);
  p_busy_after_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_quiet_wait_r6: assert property (@(posedge clk) disable iff (!rst_n) (st == S_CWAIT) |-> cs_n);
  p_ready_after_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> ($past(st) == S_CFG || $past(st) == S_READ));
endmodule

// File: tb/test_adc_seq.sv
module test_adc_seq;
  localparam int US_T = 1, MSU = 10, RSTU = 20, RW = 24;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, miso = 1'b0;
  logic [1:0] req_chan = '0;
  logic [2:0] req_gain = '0, req_rate = '0;
  logic req_ready, res_valid, sclk, mosi, cs_n;
  logic [RW-1:0] res_data;

  always #5 clk = ~clk;

  adc_seq #(.SCLK_DIV(2), .US_TICKS(US_T), .MS_US(MSU), .RST_US(RSTU), .RES_W(RW)) i_adc_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_gain(req_gain), .req_rate(req_rate),
    .res_valid(res_valid), .res_data(res_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] regs [4];
  int wlog [16];
  int nb = 0, nwr = 0, nreg1w = 0, nstart = 0, nread = 0, nrst = 0, nbad = 0;
  int t_fall = 0, t_rst_end = 0, t_cfg_begin = 0, t_start_end = 0, t_read_begin = 0;
  logic [23:0] in_sh = '0, out_sh = '0;

  always @(negedge cs_n) begin
    nb = 0; in_sh = '0; t_fall = cyc;
    out_sh = {8'h00, regs[0], ~regs[0]};
  end
  always @(negedge sclk) if (cs_n === 1'b0) begin in_sh = {in_sh[22:0], mosi}; nb++; end
  always @(posedge sclk) if (cs_n === 1'b0) begin miso <= out_sh[23]; out_sh = {out_sh[22:0], 1'b0}; end
  always @(posedge cs_n) begin
    if (nb == 8) begin
      if (in_sh[7:0] == 8'h06) begin nrst++; t_rst_end = cyc; end
      else if (in_sh[7:0] == 8'h08) begin nstart++; t_start_end = cyc; end
      else nbad++;
    end else if (nb == 16) begin
      if (in_sh[15:12] == 4'h4 && in_sh[9:8] == 2'b00) begin
        regs[in_sh[11:10]] = in_sh[7:0];
        if (nwr < 16) wlog[nwr] = int'(in_sh[11:10]);
        if (nwr == 0) t_cfg_begin = t_fall;
        nwr++;
        if (in_sh[11:10] == 2'd1) nreg1w++;
      end else nbad++;
    end else if (nb == 24) begin
      if (in_sh[23:16] == 8'h10) begin nread++; t_read_begin = t_fall; end
      else nbad++;
    end else if (nb != 0) nbad++;
    nb = 0;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int wait_ms(input logic [2:0] r);
    case (r)
      3'd0: return 51; 3'd1: return 24; 3'd2: return 13; 3'd3: return 7;
      3'd4: return 4;  3'd5: return 3;  default: return 2;
    endcase
  endfunction

  // {chan, gain, rate}
  localparam logic [7:0] VEC [6] = '{
    {2'd0, 3'd0, 3'd3}, {2'd1, 3'd2, 3'd0}, {2'd2, 3'd5, 3'd0},
    {2'd3, 3'd7, 3'd6}, {2'd0, 3'd1, 3'd7}, {2'd2, 3'd3, 3'd1}};

  logic [2:0] last_rate = 3'd3;
  bit done = 0;

  task automatic convert(input logic [1:0] c, input logic [2:0] g, input logic [2:0] r, input bit hold);
    logic [7:0] r0;
    logic [2:0] eff;
    logic [RW-1:0] exp_res;
    int n1, ns, elapsed, w;
    bit busy_ok;
    n1 = nreg1w; ns = nstart; busy_ok = 1;
    eff = (r == 3'd7) ? 3'd6 : r;
    r0 = {1'b1, 1'b0, c, g, 1'b1};
    exp_res = {{(RW-16){r0[7]}}, r0, ~r0};
    while (!req_ready) @(negedge clk);
    req_chan = c; req_gain = g; req_rate = r; req_valid = 1'b1;
    @(negedge clk);
    if (hold) begin req_chan = ~c; req_gain = ~g; req_rate = 3'd2; end
    else req_valid = 1'b0;
    while (!res_valid) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(res_data == exp_res, "R7 result", res_data, exp_res);
    chk(regs[0] == r0, "R4 reg0 value", regs[0], r0);
    chk(nreg1w - n1 == ((eff != last_rate) ? 1 : 0), "R5 reg1 write count", nreg1w - n1, (eff != last_rate));
    chk(regs[1] == {eff, 5'b0}, "R5 reg1 value", regs[1], {eff, 5'b0});
    w = wait_ms(eff) * MSU * US_T;
    elapsed = t_read_begin - t_start_end;
    chk(elapsed >= w && elapsed <= w + 6, "R6 conversion wait", elapsed, w);
    chk(nstart - ns == 1, "R6 one start per conversion", nstart - ns, 1);
    chk(busy_ok, "R3 ready low while busy", busy_ok, 1);
    last_rate = eff;
    @(negedge clk);
    chk(!res_valid, "R7 valid is one cycle", res_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) regs[i] = 8'hXX;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !req_ready && !res_valid, "R1 reset state",
        {cs_n, sclk, req_ready, res_valid}, 4'b1000);
    rst_n = 1'b1;
    while (!req_ready) @(negedge clk);
    chk(nrst == 1, "R1 reset opcode sent", nrst, 1);
    chk(t_cfg_begin - t_rst_end >= RSTU * US_T, "R1 reset wait", t_cfg_begin - t_rst_end, RSTU * US_T);
    chk(nwr == 4 && wlog[0] == 0 && wlog[1] == 1 && wlog[2] == 2 && wlog[3] == 3, "R2 write order",
        {wlog[0][3:0], wlog[1][3:0], wlog[2][3:0], wlog[3][3:0]}, 16'h0123);
    chk({regs[0], regs[1], regs[2], regs[3]} == 32'h8160C000, "R2 config values",
        {regs[0], regs[1], regs[2], regs[3]}, 32'h8160C000);
    chk(nstart == 0 && nread == 0, "R2 no conversion during init", nstart + nread, 0);
    for (int v = 0; v < 6; v++) convert(VEC[v][7:6], VEC[v][5:3], VEC[v][2:0], 0);
    convert(2'd1, 3'd4, 3'd5, 1);
    chk(nbad == 0, "R8 all frames well formed", nbad, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule